// File: doc/BRIEF.md
# Quadrature Reference Generator for Synchronous Detection

This block is the timing heart of a digital lock-in measurement. It runs a prescaler on the core clock that produces one step tick every `CLK_DIV` clocks, and a circular 16-position phase counter that advances on each tick. The counter drives a 4-bit stepped-sine code for an external resistor-ladder DAC, which gives a tone at one sixteenth of the step rate. With the defaults (40 MHz clock, 100 clocks per step) the steps come at 400 kHz and the tone is 25 kHz.

The same step tick fires an ADC convert strobe, so every sample is taken at a known point of the drive waveform. For each sample the block also provides a signed Q15 in-phase reference (sine) and a quadrature reference (cosine, which is the same table read one quarter cycle ahead). A downstream phase-sensitive detector multiplies the sample by these references. A 4-bit phase offset is added to the counter before the reference lookup, which trims the sample-to-drive phase in steps of 22.5 degrees. A one-clock marker flags the sample at which the drive counter wraps, so batch processing can realign to the start of the waveform.

Top module: `quad_ref_gen`

## Requirements
- R1: While `rst` is high and on the clock after it falls, `dac_code` is 8, `ref_i` and `ref_q` are 0, `adc_conv` and `cycle_start` are 0, and the phase counter is 0.
- R2: While `en` is high, `adc_conv` is a one-clock pulse that occurs exactly every `CLK_DIV` clocks. The first pulse comes `CLK_DIV` clocks after reset is released or after `en` rises. Each pulse marks one step of the phase counter p (mod 16).
- R3: After a step, `dac_code` equals entry p of the table {8,11,13,14,15,14,13,11,8,5,3,2,1,2,3,5}. It is never 0.
- R4: After a step, `ref_i` equals the Q15 sine S[(p+phase_ofs) mod 16]. S is {0,12540,23170,30274,32767,30274,23170,12540} for indices 0..7, and the negated values for 8..15. `phase_ofs` is sampled on the clock of the step.
- R5: After a step, `ref_q` equals S[(p+phase_ofs+4) mod 16], a cosine that leads `ref_i` by a quarter cycle. So `ref_q` is 0 exactly when `ref_i` is ±32767.
- R6: `cycle_start` pulses together with `adc_conv` on the step at which p wraps from 15 to 0, and only then: once every 16 steps.
- R7: While `en` is low, no strobes occur, the prescaler clears, and p and all data outputs hold their values.
- R8: `dac_code`, `ref_i` and `ref_q` change only on clocks where `adc_conv` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable for prescaler and phase counter |
| phase_ofs | input | 4 | Reference index offset, in sixteenths of a cycle |
| dac_code | output | 4 | Stepped-sine ladder code |
| ref_i | output | 16 | Signed Q15 in-phase reference |
| ref_q | output | 16 | Signed Q15 quadrature reference |
| adc_conv | output | 1 | One-clock ADC convert strobe per step |
| cycle_start | output | 1 | One-clock marker on drive counter wrap |

## Verification
On every cycle the assertions check that the strobes are single-clock pulses, that the wrap marker only appears with a convert strobe and exactly every sixteenth step, that the data outputs stay stable between steps, that the cosine and sine references agree on their zero and peak points, that the ladder code never reaches 0, and that a low enable suppresses strobes. Only the bench's scenarios can show the exact table values at each phase, the effect of several offset settings (including a change in mid-run), the exact step period, and that the prescaler restarts after enable or reset pauses.

// File: rtl/qrg_pkg.sv
package qrg_pkg;
  localparam int PH_W  = 4;
  localparam int STEPS = 1 << PH_W;
  localparam int REF_W = 16;
  localparam int DRV_W = 4;
  localparam logic [DRV_W-1:0] DRV_MID = DRV_W'(1 << (DRV_W - 1));

  // Magnitude of a 16-point sine on its rising quarter, index 0..4
  function automatic logic [REF_W-1:0] quarter_mag(input logic [2:0] m);
    case (m)
      3'd0:    quarter_mag = 16'd0;
      3'd1:    quarter_mag = 16'd12540;
      3'd2:    quarter_mag = 16'd23170;
      3'd3:    quarter_mag = 16'd30274;
      default: quarter_mag = 16'd32767;
    endcase
  endfunction

  function automatic logic [DRV_W-1:0] quarter_lvl(input logic [2:0] m);
    case (m)
      3'd0:    quarter_lvl = 4'd0;
      3'd1:    quarter_lvl = 4'd3;
      3'd2:    quarter_lvl = 4'd5;
      3'd3:    quarter_lvl = 4'd6;
      default: quarter_lvl = 4'd7;
    endcase
  endfunction

  // Fold a half-cycle position 0..7 onto the quarter index 0..4
  function automatic logic [2:0] fold(input logic [PH_W-2:0] h);
    fold = (h > 3'd4) ? 3'(4'd8 - {1'b0, h}) : h;
  endfunction

  function automatic logic signed [REF_W-1:0] sine_q15(input logic [PH_W-1:0] k);
    logic [REF_W-1:0] mag;
    mag = quarter_mag(fold(k[PH_W-2:0]));
    sine_q15 = k[PH_W-1] ? -$signed(mag) : $signed(mag);
  endfunction

  function automatic logic [DRV_W-1:0] ladder_code(input logic [PH_W-1:0] k);
    logic [DRV_W-1:0] lvl;
    lvl = quarter_lvl(fold(k[PH_W-2:0]));
    ladder_code = k[PH_W-1] ? DRV_MID - lvl : DRV_MID + lvl;
  endfunction
endpackage

// File: rtl/qrg_prescaler.sv
module qrg_prescaler #(
  parameter int CLK_DIV = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en || tick) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/qrg_phase_acc.sv
module qrg_phase_acc
  import qrg_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  output logic [PH_W-1:0] ph,
  output logic [PH_W-1:0] ph_next,
  output logic            wrap
);
  assign ph_next = ph + 1'b1;
  assign wrap    = tick && (ph == PH_W'(STEPS - 1));

  always_ff @(posedge clk) begin
    if (rst)       ph <= '0;
    else if (tick) ph <= ph_next;
  end
endmodule

// File: rtl/qrg_lookup.sv
module qrg_lookup
  import qrg_pkg::*;
(
  input  logic [PH_W-1:0]         drv_idx,
  input  logic [PH_W-1:0]         ofs,
  output logic [DRV_W-1:0]        code,
  output logic signed [REF_W-1:0] sin_w,
  output logic signed [REF_W-1:0] cos_w
);
  localparam logic [PH_W-1:0] QUARTER = PH_W'(STEPS / 4);

  logic [PH_W-1:0] ref_idx;

  always_comb begin
    ref_idx = drv_idx + ofs;
    code    = ladder_code(drv_idx);
    sin_w   = sine_q15(ref_idx);
    cos_w   = sine_q15(ref_idx + QUARTER);
  end
endmodule

// File: rtl/quad_ref_gen.sv
module quad_ref_gen
  import qrg_pkg::*;
#(
  parameter int CLK_DIV = 100
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [3:0]              phase_ofs,
  output logic [3:0]              dac_code,
  output logic signed [15:0]      ref_i,
  output logic signed [15:0]      ref_q,
  output logic                    adc_conv,
  output logic                    cycle_start
);
  logic                    tick;
  logic                    wrap;
  logic [PH_W-1:0]         ph;
  logic [PH_W-1:0]         ph_next;
  logic [DRV_W-1:0]        code_nx;
  logic signed [REF_W-1:0] sin_nx;
  logic signed [REF_W-1:0] cos_nx;

  qrg_prescaler #(.CLK_DIV(CLK_DIV)) u_pre (
    .clk(clk), .rst(rst), .en(en), .tick(tick)
  );

  qrg_phase_acc u_ph (
    .clk(clk), .rst(rst), .tick(tick),
    .ph(ph), .ph_next(ph_next), .wrap(wrap)
  );

  qrg_lookup u_lut (
    .drv_idx(ph_next), .ofs(phase_ofs),
    .code(code_nx), .sin_w(sin_nx), .cos_w(cos_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_code    <= DRV_MID;
      ref_i       <= '0;
      ref_q       <= '0;
      adc_conv    <= 1'b0;
      cycle_start <= 1'b0;
    end else begin
      adc_conv    <= tick;
      cycle_start <= wrap;
      if (tick) begin
        dac_code <= code_nx;
        ref_i    <= sin_nx;
        ref_q    <= cos_nx;
      end
    end
  end
endmodule

// File: rtl/quad_ref_gen_chk.sv
module quad_ref_gen_chk (
  input logic               clk,
  input logic               rst,
  input logic               en,
  input logic [3:0]         dac_code,
  input logic signed [15:0] ref_i,
  input logic signed [15:0] ref_q,
  input logic               adc_conv,
  input logic               cycle_start
);
  logic [3:0] steps_seen;

  always_ff @(posedge clk) begin
    if (rst)              steps_seen <= '0;
    else if (cycle_start) steps_seen <= '0;
    else if (adc_conv)    steps_seen <= steps_seen + 1'b1;
  end

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    adc_conv |=> !adc_conv);

  assert_no_code_zero_R3: assert property (@(posedge clk) disable iff (rst)
    dac_code != 4'd0);

  assert_quad_zero_R5: assert property (@(posedge clk) disable iff (rst)
    adc_conv |-> ((ref_q == 16'sd0) == (ref_i == 16'sd32767 || ref_i == -16'sd32767)));

  assert_marker_with_conv_R6: assert property (@(posedge clk) disable iff (rst)
    cycle_start |-> adc_conv);

  assert_marker_every_16_R6: assert property (@(posedge clk) disable iff (rst)
    cycle_start |-> (steps_seen == 4'd15));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> !adc_conv);

  assert_hold_between_R8: assert property (@(posedge clk) disable iff (rst)
    !adc_conv |-> ($stable(dac_code) && $stable(ref_i) && $stable(ref_q)));
endmodule

bind quad_ref_gen quad_ref_gen_chk u_chk (
  .clk(clk), .rst(rst), .en(en), .dac_code(dac_code), .ref_i(ref_i),
  .ref_q(ref_q), .adc_conv(adc_conv), .cycle_start(cycle_start)
);

// File: tb/test_quad_ref_gen.sv
module test_quad_ref_gen;
  localparam int CLK_PERIOD = 25;
  localparam int DIV        = 100;
  localparam int WATCHDOG   = 150000;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               en  = 1'b0;
  logic [3:0]         phase_ofs = 4'd0;
  logic [3:0]         dac_code;
  logic signed [15:0] ref_i;
  logic signed [15:0] ref_q;
  logic               adc_conv;
  logic               cycle_start;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  // Behavioural model state
  int m_pre = 0, m_ph = 0;
  int m_code = 8, m_i = 0, m_q = 0, m_conv = 0, m_cs = 0;
  int lvl_tab[16] = '{8,11,13,14,15,14,13,11,8,5,3,2,1,2,3,5};
  int sin_tab[16] = '{0,12540,23170,30274,32767,30274,23170,12540,
                      0,-12540,-23170,-30274,-32767,-30274,-23170,-12540};

  quad_ref_gen #(.CLK_DIV(DIV)) i_quad_ref_gen (
    .clk(clk), .rst(rst), .en(en), .phase_ofs(phase_ofs),
    .dac_code(dac_code), .ref_i(ref_i), .ref_q(ref_q),
    .adc_conv(adc_conv), .cycle_start(cycle_start)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cycles, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Model: one step every DIV enabled clocks; outputs registered on the step
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_pre = 0; m_ph = 0; m_code = 8; m_i = 0; m_q = 0; m_conv = 0; m_cs = 0;
    end else if (!en) begin
      m_pre = 0; m_conv = 0; m_cs = 0;
    end else if (m_pre == DIV - 1) begin
      m_pre  = 0;
      m_cs   = (m_ph == 15);
      m_ph   = (m_ph + 1) % 16;
      m_conv = 1;
      m_code = lvl_tab[m_ph];
      m_i    = sin_tab[(m_ph + phase_ofs) % 16];
      m_q    = sin_tab[(m_ph + phase_ofs + 4) % 16];
    end else begin
      m_pre++; m_conv = 0; m_cs = 0;
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    if (!done && cycles > 0) begin
      chk("R3 dac_code", dac_code, m_code);
      chk("R4 ref_i", ref_i, m_i);
      chk("R5 ref_q", ref_q, m_q);
      chk("R2 adc_conv", adc_conv, m_conv);
      chk("R6 cycle_start", cycle_start, m_cs);
    end
  end

  always @(posedge clk) begin
    if (!done && cycles > WATCHDOG) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
      summary();
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    run(3);
    // R1: reset state
    chk("R1 dac_code", dac_code, 8);
    chk("R1 ref_i", ref_i, 0);
    chk("R1 ref_q", ref_q, 0);
    chk("R1 strobes", adc_conv + cycle_start, 0);
    rst = 1'b0; en = 1'b1;
    // R2..R6: three full cycles, zero offset
    run(DIV * 16 * 3);
    // R4 R5: offset of a quarter, then odd offsets, changed mid-run
    phase_ofs = 4'd4;  run(DIV * 16);
    phase_ofs = 4'd5;  run(DIV * 7 + 13);
    phase_ofs = 4'd15; run(DIV * 20);
    // R7: enable low holds everything, prescaler restarts afterwards
    en = 1'b0; run(DIV * 3 + 7);
    en = 1'b1; run(DIV * 5 + 31);
    en = 1'b0; run(5);
    en = 1'b1; run(DIV * 18);
    // R1: reset in mid-run then resume
    rst = 1'b1; run(4);
    chk("R1 dac_code after mid reset", dac_code, 8);
    chk("R1 ref_i after mid reset", ref_i, 0);
    rst = 1'b0; phase_ofs = 4'd8;
    run(DIV * 17);
    done = 1;
    summary();
  end
endmodule